// File: doc/BRIEF.md
# Serial Flash Write-Protection Front End

This block sits at the command input of a serial flash slave and decides, for every write-type command, whether the command may go ahead. It receives SPI mode-0 frames (chip select active low, data sampled on the rising serial clock edge, MSB first). It oversamples chip select, serial clock and serial data with the system clock. It decodes six commands: write-latch set, write-latch clear, status write, page program, sector erase and bulk erase.

The block keeps a status byte. Bit 0 is the busy flag and always reads 0. Bit 1 is the write-enable latch. Bits 4:2 are the block-protect code. Bit 7 is the status-lock bit. Bits 6:5 read 0. The block also samples the active-low write-protect pin. When a frame ends, the block checks the frame length, the latch, the lock bit, the write-protect pin and the block-protect region. It then issues a one-cycle report carrying the grant decision and the target address.

The memory array, program and erase timing, and the serial output are outside this block. The serial output is never driven.

Top module: `spi_flash_wprot`

## Requirements
- R1: After reset, `status_o` reads 0x00 and `req_valid_o` is low.
- R2: Only the write-latch set command (0x06) can set status bit 1, and only in a frame of exactly 8 bits. The write-latch clear command (0x04), in a frame of exactly 8 bits, clears status bit 1. A frame of any other length changes nothing.
- R3: While status bit 7 is 0, a status write (0x01) is granted if and only if status bit 1 is set, whatever the level of `wp_ni`. A granted status write loads bit 7 and bits 4:2 from the data byte.
- R4: While status bit 7 is 1, a status write is rejected when `wp_ni` is low, even with status bit 1 set. It is granted when `wp_ni` is high and status bit 1 is set.
- R5: The hardware lock is reached in either order. Bit 7 may be set while `wp_ni` is already low, or `wp_ni` may fall after bit 7 is set. Either way, a later status write is rejected.
- R6: A bulk erase (0xC7, exactly 8 bits) is granted only if status bit 1 is set and the block-protect code is 000.
- R7: A page program (0x02, at least 40 bits) or sector erase (0xD8, exactly 32 bits) is granted only if status bit 1 is set and the low ADDR_W address bits lie outside the protected region. Code 000 protects nothing and code 111 protects everything. A code k from 1 to 6 protects the top 2^-(7-k) of the array.
- R8: Every granted status write, program or erase clears status bit 1.
- R9: A rejected command leaves the status byte unchanged, including bit 1.
- R10: A status write takes effect only in a frame of exactly 16 bits. A status write, program or erase frame of the wrong length produces no report and no status change.
- R11: Each complete status-write, program or erase frame produces exactly one single-cycle `req_valid_o` pulse. With that pulse, `req_op_o` is 0 for status write, 1 for page program, 2 for sector erase and 3 for bulk erase. `req_grant_o` gives the decision. `req_addr_o` carries the 24-bit address for program and erase, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the serial lines |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Serial chip select, active low |
| sck_i | input | 1 | Serial clock, mode 0 |
| si_i | input | 1 | Serial data in, MSB first |
| wp_ni | input | 1 | Write-protect pin, active low |
| status_o | output | 8 | Status byte |
| req_valid_o | output | 1 | Single-cycle command report strobe |
| req_op_o | output | 2 | Reported command kind |
| req_grant_o | output | 1 | 1 = accepted, 0 = rejected |
| req_addr_o | output | 24 | Target address of program/erase |

## Verification
The bench sweeps all eight combinations of write-protect pin, lock bit and latch, which separates a design that ignores the pin when the lock is clear from one that ignores the lock when the pin is low. It enters the hardware lock in both orders, to catch a design that only latches the pin level at the moment the lock is set. At the two addresses on either side of the boundary of every protection code, it issues sector erases and page programs. An off-by-one or mis-shifted region would grant the first protected address or reject the last free one. Frames that are one bit short or long must leave everything untouched, to expose a design that acts on the opcode alone.

// File: rtl/spi_wp_pkg.sv
package spi_wp_pkg;
  localparam logic [7:0] CMD_WEL_SET = 8'h06;
  localparam logic [7:0] CMD_WEL_CLR = 8'h04;
  localparam logic [7:0] CMD_STAT_WR = 8'h01;
  localparam logic [7:0] CMD_PROG    = 8'h02;
  localparam logic [7:0] CMD_SEC_ERS = 8'hD8;
  localparam logic [7:0] CMD_ALL_ERS = 8'hC7;

  localparam int unsigned OP_BITS   = 8;
  localparam int unsigned FADDR_W   = 24;
  localparam int unsigned STAT_BITS = 16;
  localparam int unsigned SEC_BITS  = OP_BITS + FADDR_W;
  localparam int unsigned PROG_MIN  = SEC_BITS + 8;

  typedef enum logic [1:0] {
    OP_STAT_WR = 2'd0,
    OP_PROG    = 2'd1,
    OP_SEC_ERS = 2'd2,
    OP_ALL_ERS = 2'd3
  } wr_op_e;
endpackage

// File: rtl/sync_2ff.sv
module sync_2ff #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      q_o    <= RST_VAL;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
  import spi_wp_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_ni,
  input  logic               sck_i,
  input  logic               si_i,
  output logic               frame_end_o,
  output logic [CNT_W-1:0]   bit_cnt_o,
  output logic [7:0]         opcode_o,
  output logic [FADDR_W-1:0] addr_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] OP_END  = CNT_W'(OP_BITS);
  localparam logic [CNT_W-1:0] ADR_END = CNT_W'(SEC_BITS);

  logic cs_s, sck_s, si_s, cs_d, sck_d;
  logic sck_rise, frame_start;

  sync_2ff #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sck_i, si_i}),
    .q_o   ({cs_s, sck_s, si_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_d  <= 1'b1;
      sck_d <= 1'b0;
    end else begin
      cs_d  <= cs_s;
      sck_d <= sck_s;
    end
  end

  assign sck_rise    = sck_s & ~sck_d & ~cs_s;
  assign frame_start = ~cs_s & cs_d;
  assign frame_end_o = cs_s & ~cs_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_o <= '0;
      opcode_o  <= '0;
      addr_o    <= '0;
    end else if (frame_start) begin
      bit_cnt_o <= '0;
      opcode_o  <= '0;
      addr_o    <= '0;
    end else if (sck_rise) begin
      if (bit_cnt_o != CNT_MAX) bit_cnt_o <= bit_cnt_o + 1'b1;
      if (bit_cnt_o < OP_END)       opcode_o <= {opcode_o[6:0], si_s};
      else if (bit_cnt_o < ADR_END) addr_o   <= {addr_o[FADDR_W-2:0], si_s};
    end
  end
endmodule

// File: rtl/wp_region.sv
module wp_region #(
  parameter int unsigned ADDR_W = 19
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        code_i,
  output logic              prot_o
);
  localparam int unsigned NCODE = 8;

  logic [NCODE-1:0] hit;

  assign hit[0]       = 1'b0;
  assign hit[NCODE-1] = 1'b1;

  // code k guards the region whose top (7-k) address bits are all ones
  for (genvar k = 1; k < NCODE - 1; k++) begin : g_code
    assign hit[k] = &addr_i[ADDR_W-1 -: (NCODE - 1 - k)];
  end

  assign prot_o = hit[code_i];
endmodule

// File: rtl/spi_flash_wprot.sv
module spi_flash_wprot
  import spi_wp_pkg::*;
#(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned CNT_W  = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cs_ni,
  input  logic        sck_i,
  input  logic        si_i,
  input  logic        wp_ni,
  output logic [7:0]  status_o,
  output logic        req_valid_o,
  output logic [1:0]  req_op_o,
  output logic        req_grant_o,
  output logic [23:0] req_addr_o
);
  localparam logic [CNT_W-1:0] N_OP   = CNT_W'(OP_BITS);
  localparam logic [CNT_W-1:0] N_STAT = CNT_W'(STAT_BITS);
  localparam logic [CNT_W-1:0] N_SEC  = CNT_W'(SEC_BITS);
  localparam logic [CNT_W-1:0] N_PROG = CNT_W'(PROG_MIN);

  logic               frame_end;
  logic [CNT_W-1:0]   bit_cnt;
  logic [7:0]         opcode;
  logic [FADDR_W-1:0] addr;
  logic               wp_s, wp_low, in_prot;

  logic       wel_q, srwd_q;
  logic [2:0] bp_q;
  logic       wel_n, srwd_n;
  logic [2:0] bp_n;
  logic       rep, grant;
  wr_op_e     op;

  spi_frame_rx #(.CNT_W(CNT_W)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_ni      (cs_ni),
    .sck_i      (sck_i),
    .si_i       (si_i),
    .frame_end_o(frame_end),
    .bit_cnt_o  (bit_cnt),
    .opcode_o   (opcode),
    .addr_o     (addr)
  );

  sync_2ff #(.W(1), .RST_VAL(1'b1)) u_wp_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (wp_ni),
    .q_o   (wp_s)
  );
  assign wp_low = ~wp_s;

  wp_region #(.ADDR_W(ADDR_W)) u_region (
    .addr_i(addr[ADDR_W-1:0]),
    .code_i(bp_q),
    .prot_o(in_prot)
  );

  always_comb begin
    wel_n  = wel_q;
    srwd_n = srwd_q;
    bp_n   = bp_q;
    rep    = 1'b0;
    grant  = 1'b0;
    op     = OP_STAT_WR;
    if (frame_end) begin
      case (opcode)
        CMD_WEL_SET: if (bit_cnt == N_OP) wel_n = 1'b1;
        CMD_WEL_CLR: if (bit_cnt == N_OP) wel_n = 1'b0;
        CMD_STAT_WR: if (bit_cnt == N_STAT) begin
          rep   = 1'b1;
          grant = wel_q & ~(srwd_q & wp_low);
          if (grant) begin
            srwd_n = addr[7];
            bp_n   = addr[4:2];
          end
        end
        CMD_PROG: if (bit_cnt >= N_PROG) begin
          rep   = 1'b1;
          op    = OP_PROG;
          grant = wel_q & ~in_prot;
        end
        CMD_SEC_ERS: if (bit_cnt == N_SEC) begin
          rep   = 1'b1;
          op    = OP_SEC_ERS;
          grant = wel_q & ~in_prot;
        end
        CMD_ALL_ERS: if (bit_cnt == N_OP) begin
          rep   = 1'b1;
          op    = OP_ALL_ERS;
          grant = wel_q & (bp_q == 3'b000);
        end
        default: ;
      endcase
      if (rep && grant) wel_n = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_q       <= 1'b0;
      srwd_q      <= 1'b0;
      bp_q        <= 3'b000;
      req_valid_o <= 1'b0;
      req_op_o    <= 2'd0;
      req_grant_o <= 1'b0;
      req_addr_o  <= '0;
    end else begin
      wel_q       <= wel_n;
      srwd_q      <= srwd_n;
      bp_q        <= bp_n;
      req_valid_o <= rep;
      if (rep) begin
        req_op_o    <= op;
        req_grant_o <= grant;
        req_addr_o  <= (op == OP_PROG || op == OP_SEC_ERS) ? addr : '0;
      end
    end
  end

  assign status_o = {srwd_q, 2'b00, bp_q, wel_q, 1'b0};
endmodule

// File: rtl/spi_flash_wprot_chk.sv
module spi_flash_wprot_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [7:0]  status_i,
  input logic        req_valid_i,
  input logic [1:0]  req_op_i,
  input logic        req_grant_i,
  input logic        wp_low_i
);
  p_grant_needs_wel_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_grant_i |-> $past(status_i[1]) && !status_i[1]);

  p_hw_lock_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_op_i == 2'd0 && $past(status_i[7]) && $past(wp_low_i) |-> !req_grant_i);

  p_reject_keeps_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !req_grant_i |-> status_i == $past(status_i));

  p_bulk_guard_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_op_i == 2'd3 && $past(status_i[4:2]) != 3'b000 |-> !req_grant_i);

  p_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> !req_valid_i);

  p_fixed_bits_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_i[0] == 1'b0 && status_i[6:5] == 2'b00);
endmodule

bind spi_flash_wprot spi_flash_wprot_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .status_i   (status_o),
  .req_valid_i(req_valid_o),
  .req_op_i   (req_op_o),
  .req_grant_i(req_grant_o),
  .wp_low_i   (wp_low)
);

// File: tb/tb_spi_flash_wprot.sv
module tb_spi_flash_wprot;
  localparam int AW = 19;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, wp_n = 1'b1;
  logic [7:0]  status;
  logic        req_valid, req_grant;
  logic [1:0]  req_op;
  logic [23:0] req_addr;

  int vectors = 0, fails = 0;
  bit done = 0;
  logic [26:0] expq[$];

  logic       m_wel = 0, m_srwd = 0;
  logic [2:0] m_bp = 0;

  always #4 clk = ~clk;

  spi_flash_wprot dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .si_i(si), .wp_ni(wp_n),
    .status_o(status), .req_valid_o(req_valid), .req_op_o(req_op),
    .req_grant_o(req_grant), .req_addr_o(req_addr)
  );

  function automatic logic [7:0] exp_status();
    return {m_srwd, 2'b00, m_bp, m_wel, 1'b0};
  endfunction

  function automatic bit mprot(logic [23:0] a, logic [2:0] bp);
    int unsigned lo, size;
    lo = int'(a[AW-1:0]);
    size = 1 << AW;
    if (bp == 3'd0) return 0;
    if (bp == 3'd7) return 1;
    return lo >= size - (size >> (7 - int'(bp)));
  endfunction

  // monitor: pops expected reports
  always @(negedge clk) begin
    if (rst_n && req_valid) begin
      vectors++;
      if (expq.size() == 0) begin
        fails++;
        $display("FAIL R11 unexpected report op=%0d grant=%0b addr=%h, expected none", req_op, req_grant, req_addr);
      end else begin
        logic [26:0] e;
        e = expq.pop_front();
        if ({req_op, req_grant, req_addr} !== e) begin
          fails++;
          $display("FAIL R11 report got op=%0d g=%0b a=%h expected op=%0d g=%0b a=%h",
                   req_op, req_grant, req_addr, e[26:25], e[24], e[23:0]);
        end
      end
    end
  end

  task automatic chk_status(string req);
    vectors++;
    if (status !== exp_status() || expq.size() != 0) begin
      fails++;
      $display("FAIL %s status=%h expected=%h pending=%0d", req, status, exp_status(), expq.size());
    end
  endtask

  task automatic model(logic [63:0] b, int n);
    logic [7:0] op;
    logic [23:0] a;
    bit g;
    op = b[63:56];
    a  = b[55:32];
    case (op)
      8'h06: if (n == 8) m_wel = 1;
      8'h04: if (n == 8) m_wel = 0;
      8'h01: if (n == 16) begin
        g = m_wel && !(m_srwd && !wp_n);
        expq.push_back({2'd0, g, 24'h0});
        if (g) begin m_srwd = b[55]; m_bp = b[52:50]; m_wel = 0; end
      end
      8'h02: if (n >= 40) begin
        g = m_wel && !mprot(a, m_bp);
        expq.push_back({2'd1, g, a});
        if (g) m_wel = 0;
      end
      8'hD8: if (n == 32) begin
        g = m_wel && !mprot(a, m_bp);
        expq.push_back({2'd2, g, a});
        if (g) m_wel = 0;
      end
      8'hC7: if (n == 8) begin
        g = m_wel && (m_bp == 3'd0);
        expq.push_back({2'd3, g, 24'h0});
        if (g) m_wel = 0;
      end
      default: ;
    endcase
  endtask

  task automatic frame(logic [63:0] b, int n, string req);
    @(negedge clk); cs_n = 0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      si = b[63-i];
      repeat (4) @(negedge clk); sck = 1;
      repeat (4) @(negedge clk); sck = 0;
    end
    repeat (4) @(negedge clk);
    cs_n = 1;
    model(b, n);
    repeat (10) @(negedge clk);
    chk_status(req);
  endtask

  task automatic wren(); frame({8'h06, 56'h0}, 8, "R2"); endtask
  task automatic wrdi(); frame({8'h04, 56'h0}, 8, "R2"); endtask
  task automatic wrsr(logic [7:0] d, string req); frame({8'h01, d, 48'h0}, 16, req); endtask
  task automatic se(logic [23:0] a); frame({8'hD8, a, 32'h0}, 32, "R7"); endtask
  task automatic pp(logic [23:0] a); frame({8'h02, a, 8'hA5, 24'h0}, 40, "R7"); endtask
  task automatic set_wp(logic v); wp_n = v; repeat (6) @(negedge clk); endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    vectors++;
    if (status !== 8'h00 || req_valid !== 1'b0) begin
      fails++; $display("FAIL R1 status=%h valid=%b expected 00/0", status, req_valid);
    end
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk_status("R1");

    // R2: latch control and lengths
    frame({8'h06, 56'h0}, 9, "R2");
    frame({8'h06, 56'h0}, 7, "R2");
    wren(); wrdi(); wren();
    // R10: bad lengths for status write and erase
    frame({8'h01, 8'h9C, 48'h0}, 15, "R10");
    frame({8'h01, 8'h9C, 48'h0}, 17, "R10");
    frame({8'hD8, 24'h000100, 32'h0}, 31, "R10");
    frame({8'h02, 24'h000100, 32'h0}, 39, "R10");
    // R3: status write without latch rejected; then with latch
    wrdi();
    wrsr(8'h0C, "R3");
    // R6: bulk erase with bp=0
    wren(); frame({8'hC7, 56'h0}, 8, "R6");
    frame({8'hC7, 56'h0}, 8, "R6");

    // R3 R4: sweep of pin, lock bit, latch
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < 2; s++)
        for (int l = 0; l < 2; l++) begin
          set_wp(1);
          wren(); wrsr(s ? 8'h80 : 8'h00, "R4");
          if (l != 0) wren(); else wrdi();
          set_wp(w[0]);
          wrsr(8'h94, s ? "R4" : "R3");
          set_wp(1);
        end

    // R5: pin low first, then lock
    set_wp(1); wren(); wrsr(8'h00, "R5");
    set_wp(0); wren(); wrsr(8'h80, "R5");
    wren(); wrsr(8'h00, "R5");
    // R5: lock first, then pin low
    set_wp(1); wren(); wrsr(8'h00, "R5");
    wren(); wrsr(8'h80, "R5");
    set_wp(0); wren(); wrsr(8'h1C, "R5");
    set_wp(1); wren(); wrsr(8'h00, "R5");

    // R7 R6: region boundaries per code
    for (int k = 0; k < 8; k++) begin
      int unsigned size, base;
      size = 1 << AW;
      base = (k == 0) ? size : (k == 7) ? 0 : size - (size >> (7 - k));
      wren(); wrsr(8'(k << 2), "R7");
      wren(); frame({8'hC7, 56'h0}, 8, "R6");
      if (base > 0) begin wren(); se(24'(base - 1)); wren(); pp(24'(base - 1)); end
      if (base < size) begin wren(); se(24'(base)); wren(); pp(24'(base)); end
      // R8: latch clear observed in status after a grant; R9 after a reject
      wren(); se(24'(size - 1));
    end

    done = 1;
    finish_run();
  end
endmodule